// File: doc/BRIEF.md
# Programmable Interrupt Aggregation Controller

This block gathers 32 interrupt request lines into one sticky status word. From that word it drives two processor-facing interrupt outputs. Each line has four settings of its own: an active sense (high/rising or low/falling), a choice between level and edge detection, an enable, and a routing choice that sends the line to either the critical or the non-critical output. A status bit latches every qualifying event, whatever its enable says. Software clears a status bit by writing a 1 to that bit position.

Software reaches the block through a flat register port. The port has a word address, separate read and write strobes, and 32-bit data. Reads are combinational and return data in the same cycle as the read strobe. Writes take effect at the next clock edge. Source number k sits at data bit 31-k, so source 0 is the most significant bit. Sources 19 to 24 are not implemented.

The reset input is asynchronous and active low. It is expected to arrive already synchronised to the clock. The interrupt outputs are combinational functions of the registers, so they follow a register change in the same cycle.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: While reset is held and after it is released, every register reads 0 and both interrupt outputs are low.
- R2: A set status bit stays set until software writes 1 to it at address 0x0C0. Writing 0 to a status bit leaves it unchanged.
- R3: A status bit is set by a qualifying event even when that source's enable bit is 0. The enable never alters status.
- R4: Address 0x0C6 reads status AND enable. Writes to 0x0C6 change no register.
- R5: irq_crit is high exactly when some bit is set in status, enable and critical (0x0C3). irq_ncrit is high exactly when some bit is set in status and enable but clear in critical.
- R6: Polarity bit (0x0C4) at 1 makes a source active when high or on a rising edge. At 0 it makes the source active when low or on a falling edge.
- R7: Trigger bit (0x0C5) at 1 selects edge detection: status sets only in the cycle after a transition, and a line held active does not set it again after a clear. At 0 the source is level-sensed: a line held active sets its status again right after a clear.
- R8: When a status clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R9: Sources 19 to 24 (data bits 12 down to 7) always read 0 in every register, ignore writes, and never latch status.
- R10: Enable is at 0x0C2. Reads of any address other than 0x0C0 and 0x0C2 to 0x0C6 return 0, and so does the data bus when no read is strobed.
- R11: Source k maps to data bit 31-k in every register, so source 0 is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| irq_src | input | 32 | Interrupt request lines, source k on bit 31-k |
| addr | input | 10 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, 0 when rd_en is low |
| irq_crit | output | 1 | Critical interrupt request |
| irq_ncrit | output | 1 | Non-critical interrupt request |

## Verification
The hardest case to reach is a write-1 clear that lands in the same cycle as a fresh event on the same bit. Only one clock edge separates the two outcomes. The stimulus holds a level-sensed line active across the whole status write, which forces an event in the very cycle of the clear. Edge-mode sources get the opposite test: a clear issued while the line stays high must leave the bit at 0. Once status, enable and routing are configured, both outputs are checked through every combination of a critical and a non-critical source.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned MASK_W = 64;

  localparam logic [ADDR_W-1:0] A_STAT  = 10'h0C0;
  localparam logic [ADDR_W-1:0] A_EN    = 10'h0C2;
  localparam logic [ADDR_W-1:0] A_CRIT  = 10'h0C3;
  localparam logic [ADDR_W-1:0] A_POL   = 10'h0C4;
  localparam logic [ADDR_W-1:0] A_TRIG  = 10'h0C5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 10'h0C6;

  // Implemented-source mask: source k lives at bus bit n-1-k
  function automatic logic [MASK_W-1:0] valid_mask(int unsigned n, int unsigned lo,
                                                    int unsigned hi);
    logic [MASK_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < n; b++) begin
      m[b] = !(((n - 1 - b) >= lo) && ((n - 1 - b) <= hi));
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  output logic [N-1:0] evt
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    // trig=1: edge chosen by pol; trig=0: level chosen by pol
    assign evt[i] = trig[i]
                    ? (pol[i] ? (src[i] & ~prev_q[i]) : (~src[i] & prev_q[i]))
                    : (pol[i] ? src[i] : ~src[i]);
  end

  // Edge mode with unchanged settings cannot fire in two consecutive cycles
  assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & $past(evt) & trig & $past(trig) & ~(pol ^ $past(pol))) == '0));

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_aggr_pkg::*;
#(
  parameter int unsigned   N     = 32,
  parameter logic [N-1:0]  VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      crit_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      trig_q
);

  localparam int unsigned NREG = 4;
  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{A_EN, A_CRIT, A_POL, A_TRIG};

  logic [N-1:0]    q [NREG];
  logic [N-1:0]    d [NREG];
  logic [NREG-1:0] ld;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign ld[r] = wr_en && (addr == REG_ADDR[r]);
    assign d[r]  = wr_data & VALID;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[r] <= '0;
      else if (ld[r]) q[r] <= d[r];
    end
  end

  assign en_q   = q[0];
  assign crit_q = q[1];
  assign pol_q  = q[2];
  assign trig_q = q[3];

  assert_cfg_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((en_q | crit_q | pol_q | trig_q) & ~VALID) == '0));

  assert_cfg_onehot_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld));

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int unsigned  N     = 32,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat_q
);

  logic [N-1:0] clr_bits;
  logic [N-1:0] stat_d;

  always_comb begin
    clr_bits = clr_we ? clr_mask : '0;
    // new events win over a simultaneous clear
    stat_d   = ((stat_q & ~clr_bits) | evt) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (($past(evt & VALID) & ~stat_q) == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(stat_q) & ~stat_q) == '0));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat_q & $past(clr_mask & ~evt)) == '0));

  // R8: a clear together with an event leaves the bit set
  assert_clear_vs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_mask & evt & VALID) != '0)) |=>
      (($past(clr_mask & evt & VALID) & ~stat_q) == '0));

  assert_stat_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~VALID) == '0));

endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irq_aggr_pkg::*;
#(
  parameter int unsigned SRC_N  = 32,
  parameter int unsigned RSV_LO = 19,
  parameter int unsigned RSV_HI = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  irq_src,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [SRC_N-1:0]  wr_data,
  input  logic              rd_en,
  output logic [SRC_N-1:0]  rd_data,
  output logic              irq_crit,
  output logic              irq_ncrit
);

  localparam logic [MASK_W-1:0] VALID_W = valid_mask(SRC_N, RSV_LO, RSV_HI);
  localparam logic [SRC_N-1:0]  VALID   = VALID_W[SRC_N-1:0];

  logic [SRC_N-1:0] en_q, crit_q, pol_q, trig_q;
  logic [SRC_N-1:0] evt, stat_q, masked;
  logic             stat_clr_we;

  irq_cfg_bank #(.N(SRC_N), .VALID(VALID)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .en_q    (en_q),
    .crit_q  (crit_q),
    .pol_q   (pol_q),
    .trig_q  (trig_q)
  );

  irq_src_detect #(.N(SRC_N)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (irq_src),
    .pol   (pol_q),
    .trig  (trig_q),
    .evt   (evt)
  );

  assign stat_clr_we = wr_en && (addr == A_STAT);

  irq_status_latch #(.N(SRC_N), .VALID(VALID)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_we   (stat_clr_we),
    .clr_mask (wr_data),
    .stat_q   (stat_q)
  );

  always_comb begin
    masked    = stat_q & en_q;
    irq_crit  = |(masked & crit_q);
    irq_ncrit = |(masked & ~crit_q);
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_STAT:  rd_data = stat_q;
        A_EN:    rd_data = en_q;
        A_CRIT:  rd_data = crit_q;
        A_POL:   rd_data = pol_q;
        A_TRIG:  rd_data = trig_q;
        A_MSTAT: rd_data = masked;
        default: rd_data = '0;
      endcase
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> ((stat_q == '0) && (en_q == '0) && !irq_crit && !irq_ncrit));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_crit && !irq_ncrit));

  assert_route_crit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_q == '0) |-> !irq_crit);

  assert_mstat_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_MSTAT)) |-> ((rd_data & ~(stat_q & en_q)) == '0));

endmodule

// File: tb/irq_aggr_ctrl_test.sv
module irq_aggr_ctrl_test;
  import irq_aggr_pkg::*;

  localparam logic [31:0] IDLE = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_src;
  logic [9:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wr_data, rd_data;
  logic        irq_crit, irq_ncrit;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_aggr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_crit(irq_crit), .irq_ncrit(irq_ncrit)
  );

  function automatic logic [31:0] sb_bit(int k);
    return 32'h8000_0000 >> k;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1;
    sb.push_back('{e, req});
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(posedge clk); #1;
    irq_src = v;
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input logic ec, input logic en, input string req);
    @(negedge clk);
    checks++;
    if (irq_crit !== ec || irq_ncrit !== en) begin
      fails++;
      $display("FAIL %s: crit/ncrit actual %b%b expected %b%b", req, irq_crit, irq_ncrit, ec, en);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops the scoreboard on each read cycle
  always @(negedge clk) begin
    if (rd_en === 1'b1) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", rd_data);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (rd_data !== x.val) begin
          fails++;
          $display("FAIL %s: rd_data actual %h expected %h", x.req, rd_data, x.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b1; irq_src = IDLE; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    chk_out(1'b0, 1'b0, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: everything clear after reset
    rd(A_STAT,  32'h0, "R1 status");
    rd(A_EN,    32'h0, "R1 enable");
    rd(A_CRIT,  32'h0, "R1 critical");
    rd(A_POL,   32'h0, "R1 polarity");
    rd(A_TRIG,  32'h0, "R1 trigger");
    rd(A_MSTAT, 32'h0, "R1 masked");
    chk_out(1'b0, 1'b0, "R1 outputs");

    // R3/R11: disabled active-low level source 0 latches at MSB
    set_src(IDLE & ~sb_bit(0));
    rd(A_STAT,  sb_bit(0), "R3 R11 disabled source latches at MSB");
    rd(A_MSTAT, 32'h0, "R4 masked hides disabled");
    chk_out(1'b0, 1'b0, "R3 no output while disabled");
    set_src(IDLE);
    rd(A_STAT, sb_bit(0), "R2 held after source idles");
    wr(A_STAT, 32'h0);
    rd(A_STAT, sb_bit(0), "R2 write 0 no effect");
    wr(A_STAT, sb_bit(0));
    rd(A_STAT, 32'h0, "R2 write 1 clears");

    // R8/R7 level: clear while line held active
    set_src(IDLE & ~sb_bit(1));
    wr(A_STAT, sb_bit(1));
    rd(A_STAT, sb_bit(1), "R8 R7 clear with active level stays set");
    set_src(IDLE);
    wr(A_STAT, sb_bit(1));
    rd(A_STAT, 32'h0, "R7 level clears once inactive");

    // R9: reserved bits
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, 32'hFFFF_E07F, "R9 enable reserved read 0");
    wr(A_EN, 32'h0);
    rd(A_EN, 32'h0, "R9 enable cleared");
    set_src(IDLE & ~32'h0000_1F80);
    rd(A_STAT, 32'h0, "R9 reserved sources never latch");
    set_src(IDLE);

    // R6: active-high level on source 2
    wr(A_POL, sb_bit(2));
    rd(A_STAT, sb_bit(2), "R6 active-high latches high line");
    set_src(IDLE & ~sb_bit(2));
    wr(A_STAT, sb_bit(2));
    rd(A_STAT, 32'h0, "R6 active-high ignores low line");
    set_src(IDLE);
    wr(A_POL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R7: rising edge on source 3, falling edge on source 4
    wr(A_TRIG, sb_bit(3) | sb_bit(4));
    wr(A_POL, sb_bit(3));
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R7 edge mode idle");
    set_src(IDLE & ~sb_bit(3));
    rd(A_STAT, 32'h0, "R7 R6 rising ignores fall");
    set_src(IDLE);
    rd(A_STAT, sb_bit(3), "R7 rising edge latches");
    wr(A_STAT, sb_bit(3));
    rd(A_STAT, 32'h0, "R7 held-high edge source stays clear");
    set_src(IDLE & ~sb_bit(4));
    rd(A_STAT, sb_bit(4), "R6 R7 falling edge latches");
    set_src(IDLE);
    wr(A_STAT, sb_bit(4));
    rd(A_STAT, 32'h0, "R7 falling edge cleared");
    wr(A_TRIG, 32'h0);
    wr(A_POL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R5: routing of critical and non-critical sources
    wr(A_EN, sb_bit(0) | sb_bit(5));
    wr(A_CRIT, sb_bit(0));
    chk_out(1'b0, 1'b0, "R5 idle");
    set_src(IDLE & ~sb_bit(5));
    set_src(IDLE);
    chk_out(1'b0, 1'b1, "R5 non-critical only");
    rd(A_MSTAT, sb_bit(5), "R4 masked shows enabled");
    set_src(IDLE & ~sb_bit(0));
    set_src(IDLE);
    chk_out(1'b1, 1'b1, "R5 both outputs");
    wr(A_STAT, sb_bit(5));
    chk_out(1'b1, 1'b0, "R5 critical only");
    wr(A_EN, 32'h0);
    chk_out(1'b0, 1'b0, "R5 disabled quiet");
    rd(A_STAT, sb_bit(0), "R3 enable does not touch status");

    // R4: masked view is read-only
    wr(A_EN, sb_bit(0));
    wr(A_MSTAT, 32'h0);
    rd(A_MSTAT, sb_bit(0), "R4 write to masked ignored");
    rd(A_STAT, sb_bit(0), "R4 status unchanged by masked write");
    rd(A_EN, sb_bit(0), "R4 enable unchanged by masked write");

    // R10: undefined addresses
    rd(10'h0C1, 32'h0, "R10 hole 0x0C1");
    rd(10'h0C7, 32'h0, "R10 0x0C7");
    rd(10'h2C0, 32'h0, "R10 no alias of status");
    @(negedge clk);
    checks++;
    if (rd_data !== 32'h0) begin
      fails++;
      $display("FAIL R10: idle bus actual %h expected 00000000", rd_data);
    end

    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d reads never seen, actual %0d expected 0", sb.size(), sb.size());
    end
    summary();
    $finish;
  end

endmodule